// File: doc/BRIEF.md
# Daisy-Chained Bus Interrupt Requester

This block sits on a slave module of a backplane bus and turns a local event (a front-panel pulse, or a counter reaching its preset value) into an interrupt request. It drives one of seven active-low request lines. The line is chosen by a level register, and the block keeps an internal pending flag that only software can clear.

When the controller acknowledges a level, the acknowledge arrives on a slot-to-slot daisy chain rather than on a bussed line. The block takes the acknowledge only if its request is asserted and the level on the three address lines equals its own level. It then blocks the chain, and once the data strobe falls it returns its programmable 8-bit vector with a data acknowledge. In every other case the block passes the chain on to the next slot. When the address strobe is negated, the block ends its part of the cycle.

Top module: `vme_irq_responder`

## Requirements
- R1: During and right after reset, every request line, the chain output and the data acknowledge are high (inactive), the vector output enable is low and the pending flag is 0.
- R2: One cycle after an event strobe, the request line numbered by the level register goes low, with line k on bit k-1 of the request output. No other line changes. Level 0 sets the pending flag but drives no line.
- R3: The pending flag stays 1 until a clear strobe. If an event and a clear arrive in the same cycle, the event wins and the flag stays 1.
- R4: An acknowledge cycle starts when the chain input and the address strobe are both low. If the request is asserted and the address equals the level, the block claims the cycle and the chain output stays high. One cycle after the data strobe is seen low, the data acknowledge goes low and the vector output carries the vector register with its enable high.
- R5: If the block does not claim an acknowledge cycle, the chain output goes low one cycle after the cycle starts, and the data acknowledge stays high.
- R6: In the same cycle the data acknowledge falls, the request line is released. The pending flag stays 1, and a later acknowledge cycle at the same level is passed on.
- R7: One cycle after the address strobe returns high, the chain output and the data acknowledge are high and the vector enable is low.
- R8: Writes to the level and vector registers take effect for the next event and the next claimed acknowledge.
- R9: A clear strobe with no event drops both the pending flag and any asserted request line one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Local interrupt event strobe |
| clr_i | input | 1 | Software clear of pending flag and request |
| lvl_we_i | input | 1 | Level register write enable |
| lvl_wdata_i | input | LVL_W | Level value (0 disables the lines) |
| vec_we_i | input | 1 | Vector register write enable |
| vec_wdata_i | input | VEC_W | Vector value |
| iackin_n_i | input | 1 | Acknowledge chain input, active low |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| addr_i | input | LVL_W | Acknowledged level from the low address lines |
| irq_n_o | output | NUM_LEVELS | Request lines, active low, bit k is level k+1 |
| iackout_n_o | output | 1 | Acknowledge chain output, active low |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| vec_o | output | VEC_W | Vector returned during a claimed cycle |
| vec_oe_o | output | 1 | Vector output enable |
| pending_o | output | 1 | Pending flag as seen by software |

## Verification
Random mixes of events, clears and register writes are interleaved with acknowledge cycles. Half of those cycles use the module's own level and half use another level, so the test can tell a correct claim from a wrong claim or a missed pass-through. Directed cases cover level 0 and a clear arriving together with an event. They also cover a second acknowledge after release, which shows whether the request line was released while the pending flag was held.

// File: rtl/vmei_pkg.sv
package vmei_pkg;
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,
      ACK_CLAIM = 2'd1,
      ACK_DRIVE = 2'd2,
      ACK_PASS  = 2'd3
   } ack_state_t;
endpackage

// File: rtl/vmei_cfg.sv
module vmei_cfg #(
   parameter int LVL_W = 3,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_we_i,
   input  logic [LVL_W-1:0] lvl_wdata_i,
   input  logic             vec_we_i,
   input  logic [VEC_W-1:0] vec_wdata_i,
   output logic [LVL_W-1:0] level_o,
   output logic [VEC_W-1:0] vector_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_o  <= '0;
         vector_o <= '0;
      end else begin
         if (lvl_we_i) level_o  <= lvl_wdata_i;
         if (vec_we_i) vector_o <= vec_wdata_i;
      end
   end
endmodule

// File: rtl/vmei_req.sv
module vmei_req #(
   parameter int NUM_LEVELS     = 7,
   parameter int LVL_W          = 3,
   parameter bit RELEASE_ON_ACK = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_i,
   input  logic                  clr_i,
   input  logic                  ack_take_i,
   input  logic [LVL_W-1:0]      level_i,
   output logic                  pending_o,
   output logic                  irq_active_o,
   output logic [NUM_LEVELS-1:0] irq_n_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     pending_o <= 1'b0;
      else if (evt_i) pending_o <= 1'b1;
      else if (clr_i) pending_o <= 1'b0;
   end

   generate
      if (RELEASE_ON_ACK) begin : g_rora
         always_ff @(posedge clk) begin
            if (!rst_n)                   irq_active_o <= 1'b0;
            else if (evt_i)               irq_active_o <= 1'b1;
            else if (clr_i || ack_take_i) irq_active_o <= 1'b0;
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)     irq_active_o <= 1'b0;
            else if (evt_i) irq_active_o <= 1'b1;
            else if (clr_i) irq_active_o <= 1'b0;
         end
      end
   endgenerate

   for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_line
      assign irq_n_o[k] = !(irq_active_o && (level_i == LVL_W'(k + 1)));
   end

   assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && !clr_i) |=> pending_o);
   assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> (!pending_o && (&irq_n_o)));
endmodule

// File: rtl/vmei_ack.sv
module vmei_ack
   import vmei_pkg::*;
#(
   parameter int LVL_W = 3,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iackin_n_i,
   input  logic             as_n_i,
   input  logic             ds_n_i,
   input  logic [LVL_W-1:0] addr_i,
   input  logic             irq_active_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [VEC_W-1:0] vector_i,
   output logic             ack_take_o,
   output logic             iackout_n_o,
   output logic             dtack_n_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_oe_o
);
   ack_state_t state_q, state_d;
   logic       cyc_start, own_level;

   assign cyc_start = !iackin_n_i && !as_n_i;
   assign own_level = irq_active_i && (addr_i == level_i);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ACK_IDLE:  if (cyc_start) state_d = own_level ? ACK_CLAIM : ACK_PASS;
         ACK_CLAIM: if (as_n_i) state_d = ACK_IDLE;
                    else if (!ds_n_i) state_d = ACK_DRIVE;
         ACK_DRIVE: if (as_n_i) state_d = ACK_IDLE;
         ACK_PASS:  if (as_n_i) state_d = ACK_IDLE;
         default:   state_d = ACK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ACK_IDLE;
      else        state_q <= state_d;
   end

   assign ack_take_o  = (state_q == ACK_CLAIM) && !as_n_i && !ds_n_i;
   assign iackout_n_o = (state_q != ACK_PASS);
   assign dtack_n_o   = (state_q != ACK_DRIVE);
   assign vec_oe_o    = (state_q == ACK_DRIVE);
   assign vec_o       = vec_oe_o ? vector_i : '0;

   assert_dtack_after_ds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n_o) |-> $past(!ds_n_i));
   assert_end_on_as_R7: assert property (@(posedge clk) disable iff (!rst_n)
      as_n_i |=> (iackout_n_o && dtack_n_o && !vec_oe_o));
   assert_pass_no_dtack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !iackout_n_o |-> dtack_n_o);
endmodule

// File: rtl/vme_irq_responder.sv
module vme_irq_responder #(
   parameter int NUM_LEVELS     = 7,
   parameter int VEC_W          = 8,
   parameter bit RELEASE_ON_ACK = 1'b1,
   localparam int LVL_W         = $clog2(NUM_LEVELS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_i,
   input  logic                  clr_i,
   input  logic                  lvl_we_i,
   input  logic [LVL_W-1:0]      lvl_wdata_i,
   input  logic                  vec_we_i,
   input  logic [VEC_W-1:0]      vec_wdata_i,
   input  logic                  iackin_n_i,
   input  logic                  as_n_i,
   input  logic                  ds_n_i,
   input  logic [LVL_W-1:0]      addr_i,
   output logic [NUM_LEVELS-1:0] irq_n_o,
   output logic                  iackout_n_o,
   output logic                  dtack_n_o,
   output logic [VEC_W-1:0]      vec_o,
   output logic                  vec_oe_o,
   output logic                  pending_o
);
   if (NUM_LEVELS < 1 || NUM_LEVELS > 7) begin : g_bad_levels
      $error("NUM_LEVELS must lie in 1..7");
   end
   if (VEC_W < 8) begin : g_bad_vec
      $error("VEC_W must be at least 8");
   end

   logic [LVL_W-1:0] level;
   logic [VEC_W-1:0] vector;
   logic             irq_active, ack_take;

   vmei_cfg #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .lvl_we_i(lvl_we_i), .lvl_wdata_i(lvl_wdata_i),
      .vec_we_i(vec_we_i), .vec_wdata_i(vec_wdata_i),
      .level_o(level), .vector_o(vector)
   );

   vmei_req #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .RELEASE_ON_ACK(RELEASE_ON_ACK)) u_req (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_i),
      .ack_take_i(ack_take), .level_i(level),
      .pending_o(pending_o), .irq_active_o(irq_active), .irq_n_o(irq_n_o)
   );

   vmei_ack #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
      .clk(clk), .rst_n(rst_n),
      .iackin_n_i(iackin_n_i), .as_n_i(as_n_i), .ds_n_i(ds_n_i), .addr_i(addr_i),
      .irq_active_i(irq_active), .level_i(level), .vector_i(vector),
      .ack_take_o(ack_take), .iackout_n_o(iackout_n_o), .dtack_n_o(dtack_n_o),
      .vec_o(vec_o), .vec_oe_o(vec_oe_o)
   );

   if (RELEASE_ON_ACK) begin : g_rora_chk
      assert_release_on_dtack_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(dtack_n_o) && !$past(evt_i)) |-> ((&irq_n_o) && pending_o));
   end
   assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~irq_n_o) <= 1);
endmodule

// File: tb/sim_vme_irq_responder.sv
module sim_vme_irq_responder;
   localparam int NL = 7;
   localparam int LW = 3;
   localparam int VW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt = 1'b0, clr = 1'b0, lvl_we = 1'b0, vec_we = 1'b0;
   logic [LW-1:0] lvl_wd = '0, addr = '0;
   logic [VW-1:0] vec_wd = '0;
   logic          iackin_n = 1'b1, as_n = 1'b1, ds_n = 1'b1;
   logic [NL-1:0] irq_n;
   logic          iackout_n, dtack_n, vec_oe, pending;
   logic [VW-1:0] vec;

   int n_chk = 0, n_fail = 0;
   bit m_pend = 0, m_irq = 0;
   logic [LW-1:0] m_lvl = '0;
   logic [VW-1:0] m_vec = '0;

   always #2 clk = ~clk;

   vme_irq_responder u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr),
      .lvl_we_i(lvl_we), .lvl_wdata_i(lvl_wd), .vec_we_i(vec_we), .vec_wdata_i(vec_wd),
      .iackin_n_i(iackin_n), .as_n_i(as_n), .ds_n_i(ds_n), .addr_i(addr),
      .irq_n_o(irq_n), .iackout_n_o(iackout_n), .dtack_n_o(dtack_n),
      .vec_o(vec), .vec_oe_o(vec_oe), .pending_o(pending)
   );

   function automatic logic [NL-1:0] exp_irq(bit act, logic [LW-1:0] lv);
      logic [NL-1:0] r = '1;
      if (act && lv != 0) r[lv-1] = 1'b0;
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic check_idle(string req);
      chk(req, 32'(irq_n), 32'(exp_irq(m_irq, m_lvl)));
      chk(req, 32'(pending), 32'(m_pend));
   endtask

   task automatic do_event();
      @(negedge clk); evt = 1'b1;
      @(negedge clk); evt = 1'b0;
      m_pend = 1; m_irq = 1;
      check_idle("R2");
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      m_pend = 0; m_irq = 0;
      check_idle("R9");
   endtask

   task automatic set_level(logic [LW-1:0] v);
      @(negedge clk); lvl_we = 1'b1; lvl_wd = v;
      @(negedge clk); lvl_we = 1'b0;
      m_lvl = v;
      check_idle("R8");
   endtask

   task automatic set_vector(logic [VW-1:0] v);
      @(negedge clk); vec_we = 1'b1; vec_wd = v;
      @(negedge clk); vec_we = 1'b0;
      m_vec = v;
   endtask

   task automatic ack_cycle(logic [LW-1:0] a);
      bit claim;
      claim = m_irq && (a == m_lvl);
      @(negedge clk); iackin_n = 1'b0; as_n = 1'b0; addr = a;
      @(negedge clk);
      chk(claim ? "R4" : "R5", 32'(iackout_n), 32'(claim));
      ds_n = 1'b0;
      @(negedge clk);
      if (claim) begin
         chk("R4", 32'(dtack_n), 0);
         chk("R4", 32'(vec_oe), 1);
         chk("R4", 32'(vec), 32'(m_vec));
         m_irq = 0;
         chk("R6", 32'(irq_n), 32'(exp_irq(0, m_lvl)));
         chk("R6", 32'(pending), 32'(m_pend));
      end else begin
         chk("R5", 32'(dtack_n), 1);
         chk("R5", 32'(iackout_n), 0);
      end
      as_n = 1'b1; ds_n = 1'b1; iackin_n = 1'b1;
      @(negedge clk);
      chk("R7", 32'(iackout_n), 1);
      chk("R7", 32'(dtack_n), 1);
      chk("R7", 32'(vec_oe), 0);
      check_idle("R6");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", 32'(irq_n), 32'h7f);
      chk("R1", 32'(iackout_n), 1);
      chk("R1", 32'(dtack_n), 1);
      chk("R1", 32'(vec_oe), 0);
      chk("R1", 32'(pending), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");

      // R2 level 0: pending but no line
      do_event();
      do_clear();
      // directed: level 5, vector A5
      set_level(3'd5);
      set_vector(8'hA5);
      do_event();
      ack_cycle(3'd3);               // R5 wrong level passes
      ack_cycle(3'd5);               // R4 claim
      ack_cycle(3'd5);               // R6 after release: passes
      // R3 event and clear together
      @(negedge clk); evt = 1'b1; clr = 1'b1;
      @(negedge clk); evt = 1'b0; clr = 1'b0;
      m_pend = 1; m_irq = 1;
      check_idle("R3");
      repeat (3) @(negedge clk);
      check_idle("R3");
      // R8 new vector and level used next time
      set_vector(8'h3C);
      set_level(3'd7);
      ack_cycle(3'd7);
      do_clear();

      // random mix, fixed seed
      void'($urandom(32'd1234));
      for (int i = 0; i < 300; i++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0, 1: do_event();
            2: do_clear();
            3: set_level(3'($urandom_range(0, 7)));
            4: set_vector(8'($urandom));
            default: begin
               logic [LW-1:0] a;
               if (m_lvl != 0 && $urandom_range(0, 1) == 1) a = m_lvl;
               else a = 3'($urandom_range(1, 7));
               ack_cycle(a);
            end
         endcase
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule